// File: doc/BRIEF.md
# Reset-Triggered Identification Stream Transmitter

This block sits beside the serial slave of a password-protected memory. When the host raises the trigger input while the device is selected and no nonvolatile write is running, the block arms itself. When the trigger falls again, it starts driving a fixed identification word onto the open-drain serial data pin, one bit per serial clock. The word is a build-time parameter that cannot be changed in operation.

The block never drives the pin outside this sequence. Deselecting the device at any point ends the sequence and puts the block back into standby. All inputs are sampled on the system clock `clk`. The integrator must synchronise them to that clock first, and the serial clock must run well below `clk`. The serial data output is a plain pin pair with no valid/ready handshake. The host paces every bit with the serial clock, so the block has no form of back-pressure.

Top module: `idstream_tx`

## Requirements
- R1: After `rst_n` is released, `ser_doe` is 0 and `ser_dout` is 1.
- R2: A rising edge on `trig` while `sel_n` is 0 and `nv_busy` is 0 arms the block. The clock after `trig` falls again, `ser_doe` is 1 and `ser_dout` carries bit 0 of `ID_WORD`.
- R3: Bits are sent least-significant first. Each falling edge of `ser_clk` moves the output to the next bit one clock later. Rising edges of `ser_clk` leave `ser_dout` unchanged.
- R4: Exactly `ID_W` bits are sent. The `ser_clk` falling edge that ends bit `ID_W-1` drops `ser_doe` to 0 one clock later. Further `ser_clk` edges do not enable the pin again.
- R5: `sel_n` at 1, whether the block is armed or sending, gives `ser_doe` = 0 one clock later. The block returns to standby, so a later `trig` fall or `ser_clk` edge drives nothing.
- R6: A rising edge on `trig` while `sel_n` is 1 does not arm the block. `ser_doe` stays 0 through the following `trig` fall and `ser_clk` edges.
- R7: A rising edge on `trig` while `nv_busy` is 1 does not arm the block. `ser_doe` stays 0 through the following `trig` fall and `ser_clk` edges.
- R8: Whenever `ser_doe` is 0, `ser_dout` is 1.
- R9: A further rising edge of `trig` while bits are being sent neither restarts nor changes the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Device select, active low |
| trig | input | 1 | Response trigger pulse input |
| ser_clk | input | 1 | Serial clock, sampled on `clk` |
| nv_busy | input | 1 | High while a nonvolatile write cycle runs |
| ser_dout | output | 1 | Data value for the serial pin |
| ser_doe | output | 1 | Pull-down enable for the open-drain pin |

## Verification
The hardest situations to reach are the short armed window between the trigger's rise and fall, and a deselect that arrives exactly when the last bit is being shifted out. The stimulus opens the armed window and then raises `sel_n` before the trigger falls. In separate runs it aborts a stream after a chosen number of serial clock falls, including the final one. A behavioural queue model in the bench holds the pending bits and is compared with both outputs on every clock. Any extra or missing enable cycle is therefore caught at once.

// File: rtl/idstream_pkg.sv
package idstream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } idstream_state_e;
endpackage

// File: rtl/idstream_edge.sv
module idstream_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  assign rise = d & ~d_q;
  assign fall = ~d & d_q;
endmodule

// File: rtl/idstream_bitsel.sv
module idstream_bitsel #(
  parameter int unsigned       ID_W      = 32,
  parameter logic [ID_W-1:0]   ID_WORD   = '0,
  parameter bit                LSB_FIRST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic last,
  output logic bit_out
);
  localparam int unsigned IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic [ID_W-1:0]  ordered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (load) idx_q <= '0;
    else if (adv)  idx_q <= idx_q + 1'b1;
  end

  generate
    if (LSB_FIRST) begin : g_lsb
      assign ordered = ID_WORD;
    end else begin : g_msb
      for (genvar i = 0; i < ID_W; i++) begin : g_rev
        assign ordered[i] = ID_WORD[ID_W-1-i];
      end
    end
  endgenerate

  assign last    = (idx_q == IDX_LAST);
  assign bit_out = ordered[idx_q];
endmodule

// File: rtl/idstream_fsm.sv
module idstream_fsm
  import idstream_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            nv_busy,
  input  logic            trig_rise,
  input  logic            trig_fall,
  input  logic            sclk_fall,
  input  logic            last,
  output idstream_state_e state,
  output logic            load,
  output logic            adv
);
  idstream_state_e nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    adv  = 1'b0;
    if (sel_n) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trig_rise && !nv_busy) nxt = ST_ARMED;
        end
        ST_ARMED: begin
          if (trig_fall) begin
            nxt  = ST_SEND;
            load = 1'b1;
          end
        end
        ST_SEND: begin
          if (sclk_fall) begin
            if (last) nxt = ST_IDLE;
            else      adv = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/idstream_tx.sv
module idstream_tx
  import idstream_pkg::*;
#(
  parameter int unsigned     ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = 32'h3B1E_C0A5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic trig,
  input  logic ser_clk,
  input  logic nv_busy,
  output logic ser_dout,
  output logic ser_doe
);
  logic            trig_rise, trig_fall;
  logic            sclk_rise_unused, sclk_fall;
  logic            load, adv, last, bit_out;
  idstream_state_e state;

  idstream_edge u_trig_edge (
    .clk(clk), .rst_n(rst_n), .d(trig),
    .rise(trig_rise), .fall(trig_fall)
  );

  idstream_edge u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .d(ser_clk),
    .rise(sclk_rise_unused), .fall(sclk_fall)
  );

  idstream_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .nv_busy(nv_busy),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .sclk_fall(sclk_fall),
    .last(last), .state(state), .load(load), .adv(adv)
  );

  idstream_bitsel #(
    .ID_W(ID_W), .ID_WORD(ID_WORD), .LSB_FIRST(1'b1)
  ) u_bitsel (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .last(last), .bit_out(bit_out)
  );

  assign ser_doe  = (state == ST_SEND);
  assign ser_dout = ser_doe ? bit_out : 1'b1;
endmodule

// File: rtl/idstream_tx_chk.sv
module idstream_tx_chk #(
  parameter int unsigned ID_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_doe
);
  logic        sclk_d;
  logic        sel_d;
  int unsigned falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b1;
      falls  <= 0;
    end else begin
      sclk_d <= ser_clk;
      sel_d  <= sel_n;
      if (!ser_doe)                 falls <= 0;
      else if (sclk_d && !ser_clk)  falls <= falls + 1;
    end
  end

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_doe |-> ser_dout);

  assert_deselect_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !ser_doe);

  assert_start_needs_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_doe && !$past(ser_doe)) |-> !sel_d);

  assert_hold_between_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_doe && !(sclk_d && !ser_clk)) |=> (!ser_doe || $stable(ser_dout)));

  assert_bit_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_doe |-> (falls < ID_W));
endmodule

bind idstream_tx idstream_tx_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
  .ser_dout(ser_dout), .ser_doe(ser_doe)
);

// File: tb/test_idstream_tx.sv
module test_idstream_tx;
  localparam int unsigned ID_W = 32;
  localparam logic [31:0] IDW  = 32'hC5A1_9E36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, trig = 1'b0, ser_clk = 1'b0, nv_busy = 1'b0;
  logic ser_dout, ser_doe;

  int total = 0, bad = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  idstream_tx #(.ID_W(ID_W), .ID_WORD(IDW)) i_idstream_tx (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .trig(trig),
    .ser_clk(ser_clk), .nv_busy(nv_busy),
    .ser_dout(ser_dout), .ser_doe(ser_doe)
  );

  // behavioural model: 0 idle, 1 armed, 2 sending
  int   m_st = 0;
  bit   m_q[$];
  logic m_tp = 0, m_sp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_q.delete(); m_tp = 0; m_sp = 0;
    end else begin
      if (sel_n) begin
        m_st = 0; m_q.delete();
      end else if (m_st == 0) begin
        if (trig && !m_tp && !nv_busy) m_st = 1;
      end else if (m_st == 1) begin
        if (!trig && m_tp) begin
          m_st = 2;
          for (int i = 0; i < ID_W; i++) m_q.push_back(IDW[i]);
        end
      end else if (!ser_clk && m_sp) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_st = 0;
      end
      m_tp = trig; m_sp = ser_clk;
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model (R8 on the idle value)
  always @(negedge clk) if (rst_n) begin
    check(phase, ser_doe, (m_st == 2), "model doe");
    check((m_st == 2) ? phase : "R8", ser_dout, (m_st == 2) ? m_q[0] : 1'b1, "model dout");
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(3); trig = 1'b0; tick(1);
  endtask

  task automatic sclk_falls(int n);
    for (int k = 0; k < n; k++) begin
      ser_clk = 1'b1; tick(3); ser_clk = 1'b0; tick(3);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    check("R1", ser_doe, 1'b0, "reset doe");
    check("R1", ser_dout, 1'b1, "reset dout");

    // R2/R3/R4 full stream
    phase = "R2"; sel_n = 1'b0; tick(2);
    pulse_trig();
    check("R2", ser_doe, 1'b1, "enable after trigger fall");
    check("R2", ser_dout, IDW[0], "first bit");
    phase = "R3";
    for (int b = 0; b < ID_W; b++) begin
      ser_clk = 1'b1; tick(2);
      check("R3", ser_dout, IDW[b], "bit held across rise");
      ser_clk = 1'b0; tick(1);
      if (b < ID_W - 1) check("R3", ser_dout, IDW[b+1], "next bit");
      else              check("R4", ser_doe, 1'b0, "release after last");
      tick(2);
    end
    phase = "R4"; sclk_falls(3);
    check("R4", ser_doe, 1'b0, "no re-enable after stream");

    // R5 abort while sending
    phase = "R5"; pulse_trig(); sclk_falls(5);
    check("R5", ser_dout, IDW[5], "mid-stream bit");
    sel_n = 1'b1; tick(1);
    check("R5", ser_doe, 1'b0, "abort on deselect");
    sel_n = 1'b0; tick(1); sclk_falls(4);
    check("R5", ser_doe, 1'b0, "stays idle after abort");

    // R5 abort while armed
    trig = 1'b1; tick(3); sel_n = 1'b1; tick(1); sel_n = 1'b0; tick(1);
    trig = 1'b0; tick(2);
    check("R5", ser_doe, 1'b0, "armed abort");

    // R5 abort at the final bit
    pulse_trig(); sclk_falls(ID_W - 1);
    check("R5", ser_dout, IDW[ID_W-1], "last bit present");
    sel_n = 1'b1; tick(1);
    check("R5", ser_doe, 1'b0, "abort on last bit");
    sel_n = 1'b0; tick(2);

    // R6 trigger while deselected
    phase = "R6"; sel_n = 1'b1; trig = 1'b1; tick(3); sel_n = 1'b0; tick(1);
    trig = 1'b0; tick(2); sclk_falls(2);
    check("R6", ser_doe, 1'b0, "no start when deselected");

    // R7 trigger while write busy
    phase = "R7"; nv_busy = 1'b1; trig = 1'b1; tick(2); nv_busy = 1'b0; tick(1);
    trig = 1'b0; tick(2); sclk_falls(2);
    check("R7", ser_doe, 1'b0, "no start when busy");

    // R9 second trigger mid-stream
    phase = "R9"; pulse_trig(); sclk_falls(7);
    pulse_trig();
    check("R9", ser_dout, IDW[7], "no restart");
    sclk_falls(ID_W - 7);
    check("R9", ser_doe, 1'b0, "ends on original count");

    phase = "R8"; tick(4);
    check("R8", ser_dout, 1'b1, "idle value");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule